// File: doc/BRIEF.md
# Event Counter Bank with Wide Writes

This block holds a small set of event counters, each W bits wide (W between 32 and 48). The first NUM_GP counters are general-purpose and the remaining NUM_FIX are fixed-function. All of them sit behind one register port that carries a 12-bit address, a 64-bit write word and a 64-bit read word. Each counter counts single-cycle event pulses while its enable bit is set. When a counter passes its top value it returns to zero and latches a sticky overflow flag.

Software can load a counter in two ways. A narrow load takes the low 32 bits of the write word and sign-extends them to W bits. A wide load takes the write word's low W bits directly, so the counter's upper bits come from the upper data word. The wide addresses exist only while the wide-write capability bit is set. In that mode, a wide load that carries any nonzero bit at or above position W is refused, and the block raises a one-cycle fault instead.

Top module: `pmc_bank`

## Requirements
- R1: After reset all counters read 0, the enable register (0x38F) and overflow register (0x390) read 0, the capability register (0x345) reads 0x2000 (bit 13 set), and fault_o is low.
- R2: A write to narrow address 0x0C1+i loads counter i with write bits [31:0] sign-extended from bit 31 to W bits, and it never faults.
- R3: While capability bit 13 is 1, a write to wide address 0x4C1+i whose bits [63:W] are all zero loads counter i with write bits [W-1:0]. Bits [31:0] come from the low word and bits [W-1:32] from the high word.
- R4: While capability bit 13 is 1, a wide write with any of bits [63:W] set leaves the counter unchanged and drives fault_o high for exactly the cycle after the write.
- R5: While capability bit 13 is 0, the wide addresses behave as unmapped: they read 0, writes to them are dropped, and no fault is raised. Only bit 13 of the capability register is writable.
- R6: Register 0x0A0 is read-only and reads W in bits [23:16], NUM_FIX in bits [15:8] and NUM_GP in bits [7:0].
- R7: A counter whose enable bit (bit i of 0x38F) is set increments by one on each cycle that ev_i[i] is high. A counter whose enable bit is clear holds its value.
- R8: An increment from 2^W-1 wraps the counter to 0 and sets bit i of 0x390. Writing 1 to that bit clears it, and writing 0 leaves it set. If a wrap and a clear happen in the same cycle, the set wins.
- R9: A write to a counter in the same cycle as its event pulse loads the written value, and that event is lost.
- R10: An unmapped address reads 0, ignores writes and never faults. This includes narrow and wide offsets at or beyond NUM_GP+NUM_FIX.
- R11: A read presented with rd_en_i returns data on rdata_o with rvalid_o high one cycle later. Counter values are zero-extended to 64 bits.
- R12: The reserved-bit fault check of R4 applies to fixed counters (index NUM_GP and above) in the same way as to general-purpose counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 64 | Write word (low and high halves) |
| ev_i | input | NUM_GP+NUM_FIX | Per-counter event pulses |
| rdata_o | output | 64 | Read word, registered |
| rvalid_o | output | 1 | Read data valid |
| fault_o | output | 1 | Reserved-bit fault pulse |

## Verification
The checks assume that a read and a write are never presented in the same cycle, and the stimulus issues only one access per transaction to honour this. Some counter checks are meaningful only in cycles with no write: the hold and wrap properties are qualified on the absence of a write in the previous cycle. The fault-isolation property likewise only applies when no event arrived with the faulting write. The bench raises events only inside dedicated pulse phases or in the single write used to test that writes take priority, so every read-back value can be predicted exactly.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] LEG_BASE   = 12'h0C1;
  localparam logic [ADDR_W-1:0] WIDE_BASE  = 12'h4C1;
  localparam logic [ADDR_W-1:0] ID_ADDR    = 12'h0A0;
  localparam logic [ADDR_W-1:0] CAP_ADDR   = 12'h345;
  localparam logic [ADDR_W-1:0] EN_ADDR    = 12'h38F;
  localparam logic [ADDR_W-1:0] OVF_ADDR   = 12'h390;
  localparam int CAP_WIDE_BIT = 13;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LEG, SEL_WIDE, SEL_ID, SEL_CAP, SEL_EN, SEL_OVF
  } sel_e;
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode import pmc_pkg::*; #(
  parameter int N     = 7,
  parameter int IDX_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cap_i,
  output sel_e              sel_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-1:0] leg_off, wide_off;

  assign leg_off  = addr_i - LEG_BASE;
  assign wide_off = addr_i - WIDE_BASE;

  always_comb begin
    sel_o = SEL_NONE;
    idx_o = '0;
    if (leg_off < ADDR_W'(N)) begin
      sel_o = SEL_LEG;
      idx_o = IDX_W'(leg_off);
    end else if (cap_i && (wide_off < ADDR_W'(N))) begin
      sel_o = SEL_WIDE;
      idx_o = IDX_W'(wide_off);
    end else if (addr_i == ID_ADDR) begin
      sel_o = SEL_ID;
    end else if (addr_i == CAP_ADDR) begin
      sel_o = SEL_CAP;
    end else if (addr_i == EN_ADDR) begin
      sel_o = SEL_EN;
    end else if (addr_i == OVF_ADDR) begin
      sel_o = SEL_OVF;
    end
  end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ev_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic         inc;

  assign inc    = en_i && ev_i && !ld_i;   // load wins over event
  assign wrap_o = inc && (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (ld_i) cnt_q <= ld_val_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_cap_i,
  input  logic         wr_enr_i,
  input  logic         wr_ovf_i,
  input  logic         cap_bit_i,
  input  logic [N-1:0] wbits_i,
  input  logic [N-1:0] wrap_i,
  output logic         cap_o,
  output logic [N-1:0] cnt_en_o,
  output logic [N-1:0] ovf_o
);
  logic         cap_q;
  logic [N-1:0] en_q, ovf_q, clr;

  assign clr = wr_ovf_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b1;
      en_q  <= '0;
      ovf_q <= '0;
    end else begin
      if (wr_cap_i) cap_q <= cap_bit_i;
      if (wr_enr_i) en_q  <= wbits_i;
      ovf_q <= (ovf_q & ~clr) | wrap_i;   // set beats clear
    end
  end

  assign cap_o    = cap_q;
  assign cnt_en_o = en_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank import pmc_pkg::*; #(
  parameter int W       = 40,
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  localparam int N      = NUM_GP + NUM_FIX,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [63:0]       wdata_i,
  input  logic [N-1:0]      ev_i,
  output logic [63:0]       rdata_o,
  output logic              rvalid_o,
  output logic              fault_o
);
  if (W < 32 || W > 48) begin : g_bad_w
    $error("pmc_bank: W must lie in 32..48");
  end

  sel_e                sel;
  logic [IDX_W-1:0]    idx;
  logic                cap;
  logic [N-1:0]        cnt_en, ovf, wrap, ld;
  logic [N-1:0][W-1:0] cnt;
  logic [63:0]         sext, rd_val;
  logic [W-1:0]        ld_val;
  logic                resv_bad, cnt_wr;
  logic [63:0]         rdata_q;
  logic                rvalid_q, fault_q;

  pmc_decode #(.N(N), .IDX_W(IDX_W)) u_dec (
    .addr_i(addr_i), .cap_i(cap), .sel_o(sel), .idx_o(idx)
  );

  assign sext     = {{32{wdata_i[31]}}, wdata_i[31:0]};
  assign resv_bad = |(wdata_i >> W);
  assign ld_val   = (sel == SEL_WIDE) ? wdata_i[W-1:0] : sext[W-1:0];
  assign cnt_wr   = wr_en_i && ((sel == SEL_LEG) || (sel == SEL_WIDE && !resv_bad));

  for (genvar i = 0; i < N; i++) begin : g_cnt
    assign ld[i] = cnt_wr && (idx == IDX_W'(i));
    pmc_counter #(.W(W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en[i]), .ev_i(ev_i[i]),
      .ld_i(ld[i]), .ld_val_i(ld_val), .cnt_o(cnt[i]), .wrap_o(wrap[i])
    );
  end

  pmc_ctrl #(.N(N)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_cap_i(wr_en_i && sel == SEL_CAP),
    .wr_enr_i(wr_en_i && sel == SEL_EN),
    .wr_ovf_i(wr_en_i && sel == SEL_OVF),
    .cap_bit_i(wdata_i[CAP_WIDE_BIT]),
    .wbits_i(wdata_i[N-1:0]),
    .wrap_i(wrap),
    .cap_o(cap), .cnt_en_o(cnt_en), .ovf_o(ovf)
  );

  always_comb begin
    unique case (sel)
      SEL_LEG, SEL_WIDE: rd_val = 64'(cnt[idx]);
      SEL_ID:            rd_val = {40'd0, 8'(W), 8'(NUM_FIX), 8'(NUM_GP)};
      SEL_CAP:           rd_val = 64'(cap) << CAP_WIDE_BIT;
      SEL_EN:            rd_val = 64'(cnt_en);
      SEL_OVF:           rd_val = 64'(ovf);
      default:           rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_val;
      fault_q  <= wr_en_i && (sel == SEL_WIDE) && resv_bad;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk #(
  parameter int W = 40,
  parameter int N = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic                rd_en_i,
  input logic [N-1:0]        ev_i,
  input logic [63:0]         rdata_o,
  input logic                rvalid_o,
  input logic                fault_o,
  input logic                cap_i,
  input logic [N-1:0]        cnt_en_i,
  input logic [N-1:0]        ovf_i,
  input logic [N-1:0][W-1:0] cnt_i
);
  AST_SINGLE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && wr_en_i)); // R11
  AST_RVALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o == $past(rd_en_i)); // R11
  AST_RDATA_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o >> W) == 64'd0); // R11
  AST_FAULT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(wr_en_i)); // R4
  AST_FAULT_NEEDS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(cap_i)); // R5
  AST_FAULT_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && $past(ev_i) == '0) |-> cnt_i == $past(cnt_i)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(ovf_i) & ~ovf_i)) |-> $past(wr_en_i)); // R8

  for (genvar i = 0; i < N; i++) begin : g_per
    AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(wr_en_i) && !$past(cnt_en_i[i])) |-> cnt_i[i] == $past(cnt_i[i])); // R7
    AST_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(wr_en_i) && $past(cnt_en_i[i] && ev_i[i]) && $past(cnt_i[i]) == '1)
        |-> (cnt_i[i] == '0 && ovf_i[i])); // R8
  end
endmodule

bind pmc_bank pmc_bank_chk #(.W(W), .N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .ev_i(ev_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .fault_o(fault_o),
  .cap_i(cap), .cnt_en_i(cnt_en), .ovf_i(ovf), .cnt_i(cnt)
);

// File: tb/pmc_bank_test.sv
`timescale 1ns/1ps
module pmc_bank_test;
  localparam int W = 40, NGP = 4, NFX = 3, N = NGP + NFX;
  localparam real CLK_P = 5.0;

  typedef struct { logic [63:0] exp; string tag; } rd_item_t;
  typedef struct { logic exp; string tag; } flt_item_t;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic wr_en = 0, rd_en = 0, wr_seen;
  logic [63:0] wdata = '0, rdata;
  logic [N-1:0] ev = '0;
  logic rvalid, fault;
  int n_cmp = 0, n_bad = 0;
  rd_item_t rd_q[$];
  flt_item_t f_q[$];

  always #(CLK_P/2) clk = ~clk;

  pmc_bank #(.W(W), .NUM_GP(NGP), .NUM_FIX(NFX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .ev_i(ev), .rdata_o(rdata), .rvalid_o(rvalid), .fault_o(fault)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) wr_seen <= 1'b0; else wr_seen <= wr_en;

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (rvalid) begin
      if (rd_q.size() == 0) chk("R11 stray rvalid", 64'd1, 64'd0);
      else begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
    if (wr_seen) begin
      if (f_q.size() != 0) begin
        flt_item_t ft;
        ft = f_q.pop_front();
        chk(ft.tag, 64'(fault), 64'(ft.exp));
      end
    end else if (fault) chk("R4 stray fault", 64'd1, 64'd0);
  end

  // driver
  task automatic wr(logic [11:0] a, logic [63:0] d, logic exp_f, string tag,
                    logic [N-1:0] e = '0);
    f_q.push_back('{exp_f, tag});
    @(negedge clk); addr = a; wdata = d; wr_en = 1; ev = e;
    @(negedge clk); wr_en = 0; ev = '0;
  endtask

  task automatic rd(logic [11:0] a, logic [63:0] exp, string tag);
    rd_q.push_back('{exp, tag});
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(logic [N-1:0] m, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ev = m;
      @(negedge clk); ev = '0;
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * CLK_P);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fault at reset", 64'(fault), 64'd0);
    rst_n = 1;
    rd(12'h0C1, 64'd0, "R1 cnt0 reset");
    rd(12'h0C7, 64'd0, "R1 cnt6 reset");
    rd(12'h345, 64'h2000, "R1 cap reset");
    rd(12'h38F, 64'd0, "R1 enable reset");
    rd(12'h390, 64'd0, "R1 ovf reset");
    // R6 id
    rd(12'h0A0, 64'h0028_0304, "R6 id");
    wr(12'h0A0, '1, 0, "R6 id write");
    rd(12'h0A0, 64'h0028_0304, "R6 id read-only");
    // R2 narrow
    wr(12'h0C2, 64'hDEAD_BEEF_8000_0001, 0, "R2 narrow neg");
    rd(12'h0C2, 64'h0000_00FF_8000_0001, "R2 R11 sext neg zext");
    wr(12'h0C3, 64'h1234_5678_7000_0000, 0, "R2 narrow pos");
    rd(12'h0C3, 64'h0000_0000_7000_0000, "R2 sext pos");
    // R3 / R4 wide
    wr(12'h4C1, 64'h0000_00AB_1234_5678, 0, "R3 wide write");
    rd(12'h0C1, 64'h0000_00AB_1234_5678, "R3 wide value");
    wr(12'h4C1, 64'h0000_0100_0000_0000, 1, "R4 reserved bit 40");
    rd(12'h4C1, 64'h0000_00AB_1234_5678, "R4 unchanged");
    // R12 fixed counter
    wr(12'h4C6, 64'h0000_0011_2233_4455, 0, "R12 fixed wide");
    wr(12'h4C6, 64'h8000_0000_0000_0000, 1, "R12 fixed fault");
    rd(12'h4C6, 64'h0000_0011_2233_4455, "R12 fixed unchanged");
    // R5 capability off
    wr(12'h345, 64'd0, 0, "R5 cap clear");
    rd(12'h345, 64'd0, "R5 cap reads 0");
    wr(12'h4C1, '1, 0, "R5 no fault when off");
    rd(12'h0C1, 64'h0000_00AB_1234_5678, "R5 write dropped");
    rd(12'h4C1, 64'd0, "R5 wide reads 0");
    wr(12'h345, 64'hFFFF_FFFF_FFFF_DFFF, 0, "R5 only bit13 writable");
    rd(12'h345, 64'd0, "R5 cap still 0");
    wr(12'h345, 64'h2000, 0, "R5 cap restore");
    rd(12'h345, 64'h2000, "R5 cap restored");
    // R10 unmapped
    wr(12'h123, '1, 0, "R10 unmapped write");
    rd(12'h123, 64'd0, "R10 unmapped read");
    rd(12'h0C8, 64'd0, "R10 narrow beyond N");
    wr(12'h4C8, 64'hFFFF_0000_0000_0000, 0, "R10 wide beyond N no fault");
    // R7 counting
    wr(12'h38F, 64'h8, 0, "R7 enable c3");
    wr(12'h0C4, 64'd5, 0, "R7 load c3");
    wr(12'h0C5, 64'd9, 0, "R7 load c4");
    pulse('1, 3);
    rd(12'h0C4, 64'd8, "R7 enabled counts");
    rd(12'h0C5, 64'd9, "R7 disabled holds");
    rd(12'h0C1, 64'h0000_00AB_1234_5678, "R7 c0 holds");
    // R8 wrap
    wr(12'h4C4, 64'h0000_00FF_FFFF_FFFE, 0, "R8 near top");
    pulse(7'h08, 2);
    rd(12'h0C4, 64'd0, "R8 wrapped");
    rd(12'h390, 64'h8, "R8 ovf set");
    wr(12'h390, 64'h0, 0, "R8 write 0");
    rd(12'h390, 64'h8, "R8 ovf sticky");
    wr(12'h390, 64'h8, 0, "R8 w1c");
    rd(12'h390, 64'h0, "R8 ovf cleared");
    // R9 priority
    wr(12'h0C4, 64'd100, 0, "R9 write with event", 7'h08);
    rd(12'h0C4, 64'd100, "R9 write wins");
    pulse(7'h08, 1);
    rd(12'h0C4, 64'd101, "R9 counting resumes");

    repeat (4) @(negedge clk);
    if (rd_q.size() != 0 || f_q.size() != 0)
      chk("R11 pending items", 64'(rd_q.size() + f_q.size()), 64'd0);
    summary();
    $finish;
  end
endmodule